// File: doc/BRIEF.md
# LED Matrix Row Scan and Shift Sequencer

This block feeds a two-half LED matrix panel from a frame store organised as bit planes. For every row pair and every bit plane it reads one byte per column, puts six colour bits on the data lines and pulses the shift clock. It then latches the shifted row, asks an external output-enable timer to light that plane, and waits for the timer to report completion before moving on. All planes of a row are sent before the row address moves.

The frame store is read through a synchronous port with one clock of latency. Bytes are fetched in strictly ascending order: row pair outermost, bit plane next, column innermost. The store holds two banks. The bank bit at the top of the read address is taken from `bank_sel` only when the fetch pointer wraps at the end of a frame, so a new picture always starts on a clean frame boundary. The weighting of each plane's on-time belongs to the external timer and is not part of this block.

Top module: `panel_scan_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk`, `lat` and `oe_start` are low, `row_addr` is 0, `rgb` is 0 and `mem_addr` is 0 (bank 0, offset 0).
- R2: Row addresses are visited in ascending order 0, 1, …, ROW_PAIRS−1 and then wrap to 0. Each address is the bitwise inverse of an internal down-counter.
- R3: A row address is held unchanged while all PLANES bit planes of that row are shifted, latched and lit. It changes only in the cycle after `oe_done` ends the last plane of the row.
- R4: Each pixel takes LOW_CYC+HIGH_CYC clocks. New data appears with `sclk` low for LOW_CYC clocks, then `sclk` is high for HIGH_CYC clocks, and `rgb` does not change while `sclk` is high.
- R5: Exactly COLS shift clock pulses are issued per bit plane.
- R6: After the last pulse of a plane, `lat` is high for exactly two consecutive clocks, starting in the clock that follows the last `sclk`-high clock. `lat` and `sclk` are never high together.
- R7: `oe_start` is a single-clock pulse in the clock after `lat` falls. No further activity occurs until `oe_done` is seen.
- R8: A plane's shifting begins only after the address is in place. The first pixel's data appears two clocks after the cycle in which the row address is presented, and `sclk` stays low during those two clocks.
- R9: Byte offsets are read in ascending order. Offset ((row×PLANES+plane)×COLS+col) supplies column col of that plane. Data returns one clock after the address.
- R10: `mem_addr` is {bank, offset}. The bank is sampled from `bank_sel` at the clock edge that loads the last byte of a frame, when the offset wraps to 0.
- R11: `rgb[5:0]` takes bits [5:0] of the fetched byte. Bit 0 is upper red, 1 upper green, 2 upper blue, 3 lower red, 4 lower green and 5 lower blue. Bits above 5 are ignored.
- R12: `oe_done` has no effect unless the sequencer is waiting for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_done | input | 1 | Strobe from the output-enable timer: the plane is finished |
| bank_sel | input | 1 | Bank to show from the next frame onward |
| mem_data | input | DATA_W | Frame store read data, one clock after `mem_addr` |
| mem_addr | output | $clog2(COLS·ROW_PAIRS·PLANES)+1 | Frame store read address {bank, offset} |
| rgb | output | 6 | Colour lines for the upper and lower halves |
| sclk | output | 1 | Shift clock |
| lat | output | 1 | Row latch |
| row_addr | output | $clog2(ROW_PAIRS) | Row pair address |
| oe_start | output | 1 | Strobe to start the output-enable timer |

## Verification
The embedded properties assume the frame store answers one clock after each address. They also assume `oe_done` matters only after an `oe_start` pulse, so the latch, address-step and pulse-shape checks depend on nothing outside this block. The bench drives a registered store model whose byte values vary in every bit, including the two ignored top bits. It answers each `oe_start` with a single `oe_done` pulse after a delay that depends on the plane and row. It also injects stray `oe_done` pulses while a plane is being shifted, and flips `bank_sel` in the middle of frames so that the wrap-time sampling is exercised.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;

   localparam int unsigned COLOR_LINES = 6;

   typedef enum logic [2:0] {
      RS_SET,
      RS_SHIFT,
      RS_LAT_A,
      RS_LAT_B,
      RS_OE,
      RS_WAIT
   } row_state_e;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_PREP,
      SH_PIX
   } shift_state_e;

endpackage

// File: rtl/scan_row_ctrl.sv
module scan_row_ctrl
   import panel_scan_pkg::*;
#(
   parameter int unsigned ROW_PAIRS = 16,
   parameter int unsigned PLANES    = 8,
   localparam int unsigned AW = $clog2(ROW_PAIRS),
   localparam int unsigned PW = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_done,
   input  logic          oe_done,
   output logic          go,
   output logic          lat,
   output logic          oe_start,
   output logic [AW-1:0] row_addr
);

   row_state_e    state;
   logic [AW-1:0] down_row;
   logic [PW-1:0] plane_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RS_SET;
         down_row   <= AW'(ROW_PAIRS - 1);
         plane_left <= PW'(PLANES - 1);
      end else begin
         case (state)
            RS_SET:   state <= RS_SHIFT;
            RS_SHIFT: if (shift_done) state <= RS_LAT_A;
            RS_LAT_A: state <= RS_LAT_B;
            RS_LAT_B: state <= RS_OE;
            RS_OE:    state <= RS_WAIT;
            RS_WAIT: begin
               if (oe_done) begin
                  state <= RS_SET;
                  if (plane_left == '0) begin
                     plane_left <= PW'(PLANES - 1);
                     down_row   <= down_row - 1'b1;
                  end else begin
                     plane_left <= plane_left - 1'b1;
                  end
               end
            end
            default:  state <= RS_SET;
         endcase
      end
   end

   assign go       = (state == RS_SET);
   assign lat      = (state == RS_LAT_A) || (state == RS_LAT_B);
   assign oe_start = (state == RS_OE);
   assign row_addr = ~down_row;

   // R6
   lat_min_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat) |=> lat);
   // R6
   lat_max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat && $past(lat)) |=> !lat);
   // R7
   oe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_start |=> !oe_start);
   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_addr) |-> go);
   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_addr) |-> (row_addr == AW'($past(row_addr) + 1'b1)));

endmodule

// File: rtl/scan_shifter.sv
module scan_shifter
   import panel_scan_pkg::*;
#(
   parameter int unsigned COLS        = 64,
   parameter int unsigned LOW_CYC     = 3,
   parameter int unsigned HIGH_CYC    = 2,
   parameter int unsigned FRAME_BYTES = 8192,
   parameter int unsigned DATA_W      = 8,
   localparam int unsigned PH_N = LOW_CYC + HIGH_CYC,
   localparam int unsigned PH_W = $clog2(PH_N),
   localparam int unsigned CW   = $clog2(COLS),
   localparam int unsigned OW   = $clog2(FRAME_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic                   bank_sel,
   input  logic [DATA_W-1:0]      mem_data,
   output logic [OW:0]            mem_addr,
   output logic [COLOR_LINES-1:0] rgb,
   output logic                   sclk,
   output logic                   done
);

   shift_state_e           st;
   logic [PH_W-1:0]        phase;
   logic [CW-1:0]          col_left;
   logic [OW-1:0]          ofs;
   logic                   bank_q;
   logic [COLOR_LINES-1:0] rgb_q;
   logic                   pix_end;
   logic                   load;

   assign pix_end = (st == SH_PIX) && (phase == PH_W'(PH_N - 1));
   assign load    = (st == SH_PREP) || (pix_end && (col_left != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SH_IDLE;
         phase    <= '0;
         col_left <= '0;
      end else begin
         case (st)
            SH_IDLE: if (go) st <= SH_PREP;
            SH_PREP: begin
               st       <= SH_PIX;
               phase    <= '0;
               col_left <= CW'(COLS - 1);
            end
            SH_PIX: begin
               if (pix_end) begin
                  phase <= '0;
                  if (col_left == '0) st <= SH_IDLE;
                  else col_left <= col_left - 1'b1;
               end else begin
                  phase <= phase + 1'b1;
               end
            end
            default: st <= SH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs    <= '0;
         bank_q <= 1'b0;
         rgb_q  <= '0;
      end else if (load) begin
         rgb_q <= mem_data[COLOR_LINES-1:0];
         if (ofs == OW'(FRAME_BYTES - 1)) begin
            ofs    <= '0;
            bank_q <= bank_sel;
         end else begin
            ofs <= ofs + 1'b1;
         end
      end
   end

   generate
      if (DATA_W > COLOR_LINES) begin : g_spare_bits
         logic spare_unused;
         assign spare_unused = ^mem_data[DATA_W-1:COLOR_LINES];
      end
   endgenerate

   assign mem_addr = {bank_q, ofs};
   assign rgb      = rgb_q;
   assign sclk     = (st == SH_PIX) && (phase >= PH_W'(LOW_CYC));
   assign done     = pix_end && (col_left == '0);

   logic [7:0] hi_run;
   logic [7:0] lo_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= sclk ? hi_run + 1'b1 : 8'd0;
         lo_run <= sclk ? 8'd0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 1'b1);
      end
   end

   // R4
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(rgb));
   // R4
   high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_run == 8'(HIGH_CYC)));
   // R4
   low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> (lo_run >= 8'(LOW_CYC)));
   // R9
   ofs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr[OW-1:0]) |->
         ((mem_addr[OW-1:0] == OW'($past(mem_addr[OW-1:0]) + 1'b1)) ||
          (mem_addr[OW-1:0] == '0)));

endmodule

// File: rtl/panel_scan_seq.sv
module panel_scan_seq
   import panel_scan_pkg::*;
#(
   parameter int unsigned COLS      = 64,
   parameter int unsigned ROW_PAIRS = 16,
   parameter int unsigned PLANES    = 8,
   parameter int unsigned LOW_CYC   = 3,
   parameter int unsigned HIGH_CYC  = 2,
   parameter int unsigned DATA_W    = 8,
   localparam int unsigned FRAME_BYTES = COLS * ROW_PAIRS * PLANES,
   localparam int unsigned MA_W = $clog2(FRAME_BYTES) + 1,
   localparam int unsigned AW   = $clog2(ROW_PAIRS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   oe_done,
   input  logic                   bank_sel,
   input  logic [DATA_W-1:0]      mem_data,
   output logic [MA_W-1:0]        mem_addr,
   output logic [COLOR_LINES-1:0] rgb,
   output logic                   sclk,
   output logic                   lat,
   output logic [AW-1:0]          row_addr,
   output logic                   oe_start
);

   generate
      if (ROW_PAIRS < 2 || (ROW_PAIRS & (ROW_PAIRS - 1)) != 0) begin : g_bad_rows
         $error("ROW_PAIRS must be a power of two of at least 2");
      end
      if (COLS < 2) begin : g_bad_cols
         $error("COLS must be at least 2");
      end
      if (PLANES < 1) begin : g_bad_planes
         $error("PLANES must be at least 1");
      end
      if (LOW_CYC < 1 || HIGH_CYC < 1) begin : g_bad_phase
         $error("LOW_CYC and HIGH_CYC must be at least 1");
      end
      if (DATA_W < COLOR_LINES) begin : g_bad_data
         $error("DATA_W must hold the six colour bits");
      end
   endgenerate

   logic go;
   logic shift_done;

   scan_row_ctrl #(
      .ROW_PAIRS (ROW_PAIRS),
      .PLANES    (PLANES)
   ) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_done (shift_done),
      .oe_done    (oe_done),
      .go         (go),
      .lat        (lat),
      .oe_start   (oe_start),
      .row_addr   (row_addr)
   );

   scan_shifter #(
      .COLS        (COLS),
      .LOW_CYC     (LOW_CYC),
      .HIGH_CYC    (HIGH_CYC),
      .FRAME_BYTES (FRAME_BYTES),
      .DATA_W      (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .bank_sel (bank_sel),
      .mem_data (mem_data),
      .mem_addr (mem_addr),
      .rgb      (rgb),
      .sclk     (sclk),
      .done     (shift_done)
   );

   // R6
   lat_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lat && sclk));
   // R8
   start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !sclk);
   // R7
   quiet_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_start |=> (!sclk && !lat));

endmodule

// File: tb/panel_scan_seq_test.sv
`timescale 1ns/1ps
module panel_scan_seq_test;

   localparam int COLS   = 4;
   localparam int ROWS   = 4;
   localparam int PLANES = 3;
   localparam int FRAME  = COLS * ROWS * PLANES;
   localparam int OW     = $clog2(FRAME);
   localparam int PIX    = 5;
   localparam int P      = PIX * COLS;
   localparam int RUN    = 2400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       oe_done = 1'b0;
   logic       bank_sel = 1'b0;
   logic [7:0] mem_data;
   logic [OW:0] mem_addr;
   logic [5:0] rgb;
   logic       sclk, lat, oe_start;
   logic [1:0] row_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   panel_scan_seq #(
      .COLS      (COLS),
      .ROW_PAIRS (ROWS),
      .PLANES    (PLANES)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .oe_done  (oe_done),
      .bank_sel (bank_sel),
      .mem_data (mem_data),
      .mem_addr (mem_addr),
      .rgb      (rgb),
      .sclk     (sclk),
      .lat      (lat),
      .row_addr (row_addr),
      .oe_start (oe_start)
   );

   function automatic logic [7:0] byte_at(int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   // registered frame store, one clock of latency
   always_ff @(posedge clk) mem_data <= byte_at(int'(mem_addr));

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference model state
   int k = 0;
   int row_m = 0;
   int plane_m = 0;
   int idx_m = 0;
   int bank_m = 0;
   int rgb_m = 0;
   int oe_cnt = 0;
   int spur = 0;

   task automatic load_byte();
      rgb_m = int'(byte_at((bank_m << OW) + idx_m)) & 63;
      idx_m++;
      if (idx_m == FRAME) begin
         idx_m  = 0;
         bank_m = int'(bank_sel);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "sclk", int'(sclk), 0);
      chk("R1", "lat", int'(lat), 0);
      chk("R1", "oe_start", int'(oe_start), 0);
      chk("R1", "row_addr", int'(row_addr), 0);
      chk("R1", "rgb", int'(rgb), 0);
      chk("R1", "mem_addr", int'(mem_addr), 0);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < RUN; cyc++) begin
         // expected outputs in this cycle
         begin
            int e_sclk;
            e_sclk = (k >= 2 && k <= P + 1 && ((k - 2) % PIX) >= 3) ? 1 : 0;
            if (k < 2) chk("R8", "sclk", int'(sclk), e_sclk);
            else if (spur > 0) chk("R12", "sclk", int'(sclk), e_sclk);
            else if (k <= P + 1) chk("R4", "sclk", int'(sclk), e_sclk);
            else chk("R5", "sclk", int'(sclk), e_sclk);
            chk("R6", "lat", int'(lat), (k == P + 2 || k == P + 3) ? 1 : 0);
            chk("R7", "oe_start", int'(oe_start), (k == P + 4) ? 1 : 0);
            if (plane_m > 0) chk("R3", "row_addr", int'(row_addr), row_m);
            else chk("R2", "row_addr", int'(row_addr), row_m);
            if (bank_m == 1) chk("R10", "rgb", int'(rgb), rgb_m);
            else if (k >= 2 && k <= P + 1) chk("R11", "rgb", int'(rgb), rgb_m);
            else chk("R9", "rgb", int'(rgb), rgb_m);
         end
         // stimulus for the coming edge
         bank_sel = ((cyc / 350) % 2) == 1;
         oe_done  = 1'b0;
         if (spur > 0) spur--;
         if (k == P + 4) begin
            oe_cnt = 1 + (1 << plane_m) + (row_m % 2);
         end else if (oe_cnt > 0) begin
            oe_cnt--;
            if (oe_cnt == 0) oe_done = 1'b1;
         end
         if (k == 7 && (row_m % 2) == 1) begin
            oe_done = 1'b1;  // stray strobe while shifting (R12)
            spur    = 4;
         end
         // advance the model across the edge
         if (k < P + 5) begin
            k++;
            if (k >= 2 && k <= P + 1 && ((k - 2) % PIX) == 0) load_byte();
         end else if (oe_done) begin
            k = 0;
            plane_m++;
            if (plane_m == PLANES) begin
               plane_m = 0;
               row_m   = (row_m + 1) % ROWS;
            end
         end
         @(negedge clk);
      end
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done_flag) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule